// File: doc/BRIEF.md
# Packed Dual-Word Floating-Point Adder

This block adds two 64-bit operands, each carrying two independent short floating-point words: an outer word and an inner word. Both words go through one shared mantissa adder that is cut into two sections, one for each word. The carry never crosses from one section to the other. The outer word is handled first and the inner word second. The operands are assumed to be aligned already, so the block only adds or subtracts the sign-magnitude mantissas and keeps the exponent of operand A. Normalization belongs to a separate block downstream.

For each word the block compares the two signs. When the signs match, the mantissas are added directly and a carry out of the mantissa field marks overflow. When the signs differ, operand B's mantissa is inverted and the block forms a ones'-complement sum with end-around carry. A complement flag is latched after that add. In the following step this flag decides whether the result comes out true or inverted, and it also picks the sign. An optional round then adds one at the guard bit (bit 0 of the mantissa field) and clears that bit.

The control is a six-state machine:
- `S_IDLE` waits for `start`. On `start` it latches the operands and the round enable, clears both overflow flags, and moves to `S_ADD_O`.
- `S_ADD_O` adds the outer mantissas. It latches the section sum, the section carry, the sign-difference flag and the complement flag. It moves to `S_FIX_O`.
- `S_FIX_O` applies complement or end-around carry and rounding. It writes the outer fields of `res` and `ovf_outer`, then moves to `S_ADD_I`.
- `S_ADD_I` and `S_FIX_I` do the same work for the inner word. `S_FIX_I` writes the inner fields of `res` and `ovf_inner`, then moves to `S_DONE`.
- `S_DONE` raises `done` for one cycle and returns to `S_IDLE`.

Top module: `pk_fadd2`

## Requirements
- R1: Field layout, MSB first. `[63]` is the outer sign and `[62:56]` the outer exponent. `[55]` is the inner sign and `[54:48]` the inner exponent. `[47:24]` is the inner mantissa and `[23:0]` the outer mantissa. A sign of 1 means negative. Each result exponent equals operand A's exponent for that word, and operand B's exponents are ignored.
- R2: When a word's two signs are equal, its result mantissa is the low 24 bits of `ma + mb`. Its result sign is A's sign.
- R3: When a word's signs differ and `ma > mb`, its result mantissa is `ma - mb` and its sign is A's sign.
- R4: When a word's signs differ and `ma <= mb`, its result mantissa is `mb - ma` and its sign is B's sign. Equal mantissas give zero with B's sign.
- R5: The two words are independent. No carry passes between the mantissa sections, and one word's result never depends on the other word's fields.
- R6: When `rnd` was high at `start`, the mantissa from R2–R4 has one added at bit 0 and bit 0 is then cleared. The carry out of this increment counts as overflow. When `rnd` was low, the mantissa is left unchanged.
- R7: For each word, the overflow flag (`ovf_outer`, `ovf_inner`) is set by a mantissa carry out in the equal-sign add or in the rounding increment. Both flags are cleared when `start` is accepted.
- R8: If `start` is sampled at clock edge k, the outer fields of `res` update at edge k+2 and the inner fields at edge k+4. `done` is high for exactly one cycle, from edge k+4 to edge k+5.
- R9: `start`, `op_a`, `op_b` and `rnd` are ignored while an operation is in progress.
- R10: Reset clears `res`, both overflow flags and `done`.
- R11: Between operations, `res` and both overflow flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| rnd | input | 1 | Round enable, sampled with `start` |
| op_a | input | 64 | Operand A (packed outer and inner word) |
| op_b | input | 64 | Operand B (packed outer and inner word) |
| res | output | 64 | Packed result |
| ovf_outer | output | 1 | Overflow of the outer word |
| ovf_inner | output | 1 | Overflow of the inner word |
| done | output | 1 | One-cycle pulse once both words are written |

## Verification
Counting from the edge that accepts `start`, the outer fields of `res` are due two edges later and the inner fields and `ovf_inner` four edges later. `done` spans the fifth cycle. The bench drives inputs on falling edges and counts falling edges after the accepting edge. At the second count it checks that the outer fields are new while the inner fields still hold the previous result. It requires `done` at the fourth count, compares the full result and flags there, and confirms `done` has dropped one cycle later. A start strobe injected into the third cycle of an operation must leave both the timing and the result unchanged.

// File: rtl/pk_fadd2_pkg.sv
package pk_fadd2_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADD_O,
        S_FIX_O,
        S_ADD_I,
        S_FIX_I,
        S_DONE
    } fsm_t;
endpackage

// File: rtl/pk_fadd2_secadd.sv
// Shared mantissa adder split into equal sections; no carry crosses a section
// boundary, each section reports its own carry out.
module pk_fadd2_secadd #(
    parameter int SEC_W = 24,
    parameter int N_SEC = 2
) (
    input  logic [N_SEC*SEC_W-1:0] a,
    input  logic [N_SEC*SEC_W-1:0] b,
    output logic [N_SEC*SEC_W-1:0] sum,
    output logic [N_SEC-1:0]       cout
);
    generate
        for (genvar g = 0; g < N_SEC; g++) begin : g_sec
            logic [SEC_W:0] t;
            assign t = {1'b0, a[g*SEC_W +: SEC_W]} + {1'b0, b[g*SEC_W +: SEC_W]};
            assign sum[g*SEC_W +: SEC_W] = t[SEC_W-1:0];
            assign cout[g] = t[SEC_W];
        end
    endgenerate
endmodule

// File: rtl/pk_fadd2_fix.sv
// Post-add step: end-around carry or complement, then optional rounding.
module pk_fadd2_fix #(
    parameter int W = 24
) (
    input  logic [W-1:0] s,
    input  logic         c,
    input  logic         diff,
    input  logic         cmp,
    input  logic         rnd,
    output logic [W-1:0] m,
    output logic         ovf
);
    logic [W-1:0] r0;
    logic [W:0]   u;

    always_comb begin
        // ones'-complement fold: true + carry, or inverted when no carry
        if (cmp) r0 = ~s;
        else     r0 = s + W'(diff & c);
        u = {1'b0, r0} + (W+1)'(rnd);
    end

    assign m   = rnd ? {u[W-1:1], 1'b0} : r0;
    assign ovf = (~diff & c) | u[W];
endmodule

// File: rtl/pk_fadd2.sv
module pk_fadd2
    import pk_fadd2_pkg::*;
#(
    parameter int MANT_W = 24,
    parameter int EXP_W  = 7,
    localparam int DATA_W = 2 * (1 + EXP_W + MANT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rnd,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res,
    output logic              ovf_outer,
    output logic              ovf_inner,
    output logic              done
);
    // field positions
    localparam int O_S  = DATA_W - 1;
    localparam int O_EH = DATA_W - 2;
    localparam int O_EL = DATA_W - 1 - EXP_W;
    localparam int I_S  = DATA_W - 2 - EXP_W;
    localparam int I_EH = I_S - 1;
    localparam int I_EL = I_S - EXP_W;
    localparam int I_MH = 2 * MANT_W - 1;
    localparam int I_ML = MANT_W;
    localparam int O_MH = MANT_W - 1;

    fsm_t state, nxt;

    logic [DATA_W-1:0] a_q, b_q;
    logic              rnd_q;
    logic [MANT_W-1:0] sum_q;
    logic              cy_q, diff_q, cmp_q;

    // operand field selection for the active pass
    logic              inner;
    logic              sa, sb, diff;
    logic [MANT_W-1:0] ma, mb, mbx;
    logic [2*MANT_W-1:0] add_a, add_b, add_s;
    logic [1:0]          add_c;
    logic [MANT_W-1:0]   sec_s;
    logic                sec_c;
    logic [MANT_W-1:0]   fix_m;
    logic                fix_ovf;

    always_comb begin
        inner = (state == S_ADD_I) || (state == S_FIX_I);
        sa    = inner ? a_q[I_S] : a_q[O_S];
        sb    = inner ? b_q[I_S] : b_q[O_S];
        ma    = inner ? a_q[I_MH:I_ML] : a_q[O_MH:0];
        mb    = inner ? b_q[I_MH:I_ML] : b_q[O_MH:0];
        diff  = sa ^ sb;
        mbx   = diff ? ~mb : mb;
        // the idle section is fed zeros
        add_a = inner ? {ma, {MANT_W{1'b0}}}  : {{MANT_W{1'b0}}, ma};
        add_b = inner ? {mbx, {MANT_W{1'b0}}} : {{MANT_W{1'b0}}, mbx};
        sec_s = inner ? add_s[I_MH:I_ML] : add_s[O_MH:0];
        sec_c = inner ? add_c[1] : add_c[0];
    end

    pk_fadd2_secadd #(
        .SEC_W (MANT_W),
        .N_SEC (2)
    ) u_add (
        .a    (add_a),
        .b    (add_b),
        .sum  (add_s),
        .cout (add_c)
    );

    pk_fadd2_fix #(
        .W (MANT_W)
    ) u_fix (
        .s    (sum_q),
        .c    (cy_q),
        .diff (diff_q),
        .cmp  (cmp_q),
        .rnd  (rnd_q),
        .m    (fix_m),
        .ovf  (fix_ovf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_ADD_O;
            S_ADD_O: nxt = S_FIX_O;
            S_FIX_O: nxt = S_ADD_I;
            S_ADD_I: nxt = S_FIX_I;
            S_FIX_I: nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q       <= '0;
            b_q       <= '0;
            rnd_q     <= 1'b0;
            sum_q     <= '0;
            cy_q      <= 1'b0;
            diff_q    <= 1'b0;
            cmp_q     <= 1'b0;
            res       <= '0;
            ovf_outer <= 1'b0;
            ovf_inner <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        a_q       <= op_a;
                        b_q       <= op_b;
                        rnd_q     <= rnd;
                        ovf_outer <= 1'b0;
                        ovf_inner <= 1'b0;
                    end
                end
                S_ADD_O, S_ADD_I: begin
                    sum_q  <= sec_s;
                    cy_q   <= sec_c;
                    diff_q <= diff;
                    cmp_q  <= diff & ~sec_c;
                end
                S_FIX_O: begin
                    res[O_S]       <= cmp_q ? sb : sa;
                    res[O_EH:O_EL] <= a_q[O_EH:O_EL];
                    res[O_MH:0]    <= fix_m;
                    ovf_outer      <= fix_ovf;
                end
                S_FIX_I: begin
                    res[I_S]       <= cmp_q ? sb : sa;
                    res[I_EH:I_EL] <= a_q[I_EH:I_EL];
                    res[I_MH:I_ML] <= fix_m;
                    ovf_inner      <= fix_ovf;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done = (state == S_DONE);
    end
endmodule

// File: rtl/pk_fadd2_chk.sv
module pk_fadd2_chk
    import pk_fadd2_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int MANT_W = 24,
    parameter int EXP_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              ovf_outer,
    input logic              ovf_inner,
    input logic [DATA_W-1:0] res,
    input fsm_t              state
);
    logic [DATA_W-1:0] outer_mask;
    assign outer_mask = {{(1 + EXP_W){1'b1}}, {(1 + EXP_W + 2*MANT_W){1'b0}}} | {{(DATA_W-MANT_W){1'b0}}, {MANT_W{1'b1}}};

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_after_inner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == S_FIX_I);

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (!ovf_outer && !ovf_inner));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> ($stable(res) && $stable(ovf_outer) && $stable(ovf_inner)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && state != S_DONE) |=> state != S_IDLE);

    // R5
    outer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADD_I || state == S_FIX_I) |=> ($stable(res & outer_mask) && $stable(ovf_outer)));
endmodule

bind pk_fadd2 pk_fadd2_chk #(
    .DATA_W (DATA_W),
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .ovf_outer (ovf_outer),
    .ovf_inner (ovf_inner),
    .res       (res),
    .state     (state)
);

// File: tb/pk_fadd2_test.sv
module pk_fadd2_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rnd = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [63:0] res;
    logic        ovf_outer, ovf_inner, done;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [63:0] OUTER_M = 64'hFF00_0000_00FF_FFFF;
    localparam logic [63:0] INNER_M = 64'h00FF_FFFF_FF00_0000;

    always #5 clk = ~clk;

    pk_fadd2 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rnd       (rnd),
        .op_a      (op_a),
        .op_b      (op_b),
        .res       (res),
        .ovf_outer (ovf_outer),
        .ovf_inner (ovf_inner),
        .done      (done)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one word per requirements R2-R4 and R6
    function automatic void word_ref(input logic sa, input logic sb,
                                     input logic [23:0] ma, input logic [23:0] mb,
                                     input logic r, output logic so,
                                     output logic [23:0] mo, output logic ov,
                                     output string cls);
        logic [24:0] t;
        ov = 1'b0;
        if (sa == sb) begin
            t = {1'b0, ma} + {1'b0, mb};
            ov = t[24]; mo = t[23:0]; so = sa; cls = "R2";
        end else if (ma > mb) begin
            mo = ma - mb; so = sa; cls = "R3";
        end else begin
            mo = mb - ma; so = sb; cls = "R4";
        end
        if (r) begin
            t = {1'b0, mo} + 25'd1;
            ov = ov | t[24];
            mo = {t[23:1], 1'b0};
            cls = {cls, "/R6"};
        end
    endfunction

    function automatic logic [63:0] pack(input logic so, input logic [6:0] eo, input logic [23:0] mo,
                                         input logic si, input logic [6:0] ei, input logic [23:0] mi);
        return {so, eo, si, ei, mi, mo};
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic r,
                          input logic spurious);
        logic so, si, ovo, ovi;
        logic [23:0] mo, mi;
        logic [63:0] exp, old;
        string co, ci;
        int n;
        word_ref(a[63], b[63], a[23:0], b[23:0], r, so, mo, ovo, co);
        word_ref(a[55], b[55], a[47:24], b[47:24], r, si, mi, ovi, ci);
        exp = pack(so, a[62:56], mo, si, a[54:48], mi);
        old = res;
        @(negedge clk);
        op_a = a; op_b = b; rnd = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (spurious) begin op_a = ~a; op_b = ~b; rnd = ~r; end
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (n == 1) start = spurious;
            if (n == 2) begin
                start = 1'b0;
                chk(res & OUTER_M, exp & OUTER_M, "R8 outer fields at edge k+2");
                chk(res & INNER_M, old & INNER_M, "R8 inner fields still old at edge k+2");
            end
        end
        chk(64'(n), 64'd4, spurious ? "R9 latency with stray start" : "R8 done latency");
        chk(res & OUTER_M, exp & OUTER_M, spurious ? {"R9 outer ", co} : {"outer ", co});
        chk(res & INNER_M, exp & INNER_M, spurious ? {"R9 inner ", ci} : {"inner ", ci});
        chk({62'd0, ovf_outer, ovf_inner}, {62'd0, ovo, ovi}, "R7 overflow flags");
        @(negedge clk);
        chk({63'd0, done}, 64'd0, "R8 done one cycle");
        op_a = '0; op_b = '0; rnd = 1'b0;
    endtask

    initial begin : watchdog
        #1_500_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [63:0] a, b, r1, f1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10
        chk(res, 64'd0, "R10 reset result");
        chk({61'd0, ovf_outer, ovf_inner, done}, 64'd0, "R10 reset flags and done");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 field placement, B exponents ignored
        run_op(pack(1'b0, 7'h55, 24'h000100, 1'b1, 7'h2A, 24'h000300),
               pack(1'b0, 7'h11, 24'h000001, 1'b1, 7'h7F, 24'h000002), 1'b0, 1'b0);
        chk(64'(res[62:56]), 64'h55, "R1 outer exponent from A");
        chk(64'(res[54:48]), 64'h2A, "R1 inner exponent from A");
        chk(64'(res[23:0]), 64'h000101, "R1 outer mantissa position");
        chk(64'(res[47:24]), 64'h000302, "R1 inner mantissa position");

        // R2 equal-sign overflow, R4 equal mantissas
        run_op(pack(1'b0, 7'h01, 24'hFFFFFF, 1'b0, 7'h02, 24'h123456),
               pack(1'b0, 7'h00, 24'h000001, 1'b1, 7'h00, 24'h123456), 1'b0, 1'b0);
        chk({62'd0, ovf_outer, ovf_inner}, 64'd2, "R2 carry out sets outer overflow only");
        chk(64'(res[47:24]), 64'd0, "R4 equal mantissas give zero");
        chk(64'(res[55]), 64'd1, "R4 zero takes B sign");

        // R6 rounding carry into overflow on differing signs
        run_op(pack(1'b1, 7'h03, 24'hFFFFFF, 1'b0, 7'h04, 24'h000005),
               pack(1'b0, 7'h00, 24'h000000, 1'b0, 7'h00, 24'h000002), 1'b1, 1'b0);
        chk({62'd0, ovf_outer, ovf_inner}, 64'd2, "R6 round carry sets overflow");
        chk(64'(res[47:24]), 64'h000008, "R6 round clears guard bit");

        // R11 hold while idle with changing inputs
        r1 = res; f1 = {62'd0, ovf_outer, ovf_inner};
        op_a = '1; op_b = 64'h1234; rnd = 1'b1;
        repeat (4) @(negedge clk);
        chk(res, r1, "R11 result held");
        chk({62'd0, ovf_outer, ovf_inner}, f1, "R11 flags held");
        op_a = '0; op_b = '0; rnd = 1'b0;

        // R5 outer result unaffected by inner fields
        a = pack(1'b0, 7'h10, 24'h400000, 1'b0, 7'h20, 24'h000001);
        b = pack(1'b1, 7'h00, 24'h100000, 1'b0, 7'h00, 24'h000001);
        run_op(a, b, 1'b0, 1'b0);
        r1 = res & OUTER_M;
        a[55:24] = 32'hFFFF_FFFF; b[55:24] = 32'h7FFF_FFFF;
        run_op(a, b, 1'b0, 1'b0);
        chk(res & OUTER_M, r1, "R5 outer independent of inner");

        // R9 stray start during operation
        run_op(pack(1'b0, 7'h05, 24'h00F000, 1'b1, 7'h06, 24'h000010),
               pack(1'b1, 7'h00, 24'h00F001, 1'b1, 7'h00, 24'h000020), 1'b0, 1'b1);

        // random mix with forced corners
        for (int i = 0; i < 300; i++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            case (i % 4)
                0: b[23:0] = a[23:0];
                1: begin b[63] = a[63]; b[55] = a[55]; end
                2: begin b[63] = ~a[63]; b[47:24] = a[47:24]; end
                default: ;
            endcase
            run_op(a, b, 1'($urandom % 2), (i % 37) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule